// File: doc/BRIEF.md
# Burst Handshake Monitor

This block watches a burst request line and two response strobes, a read-enable strobe and an acknowledge strobe, on one clock. It checks that a burst is answered as agreed. A request that drops from high to low opens a check window. After a fixed latency, both strobes must come up together. They must then stay up together for a minimum run. The request line must stay low for every cycle of the window, including the latency cycles, and not only while the strobes are active.

Each window ends with a one-cycle pass pulse or a one-cycle fail pulse. A fail also sets a sticky error flag and stores a two-bit cause code, which stays visible until software-style clearing through the clear input or a reset. The block is passive: it drives nothing back into the bus it observes. With the default parameters, the window is six cycles long: two latency cycles and a four-cycle strobe run.

Top module: `burst_hs_monitor`

## Requirements
- R1: A window opens in the cycle where `burst_req` is low and was high in the previous cycle. That trigger cycle is window cycle 0, and the default window runs through cycle 5.
- R2: After reset the monitor treats the request as not yet seen high. A request held low out of reset opens no window until it has been high for at least one cycle.
- R3: In window cycles 2 to 5, `rd_strobe` and `ack_strobe` must both be high. If either is low in one of those cycles, `win_fail` pulses in the following cycle with `fail_cause` = 2'b01 (strobe).
- R4: If `burst_req` is high in any of window cycles 1 to 5, `win_fail` pulses in the following cycle with `fail_cause` = 2'b10 (request). When a strobe fault happens in the same cycle, the request cause wins.
- R5: If a window reaches the end of cycle 5 with no fault, `win_pass` pulses in the following cycle. Strobes that stay high after cycle 5 cause no error.
- R6: `win_pass` and `win_fail` are single-cycle pulses and never high together. A window ends on its first fault and produces no further pulse.
- R7: `fail_cause` takes the code of each fail (00 means none). It holds that code through later passes, until the next fail or a clear. A clear alone returns it to 00.
- R8: `err_sticky` rises together with every `win_fail` and stays high until `clr_err` is sampled high. It then drops in the next cycle. If a fail is being reported in the same cycle as the clear, the fail wins.
- R9: The monitor can trigger again immediately. A falling request edge in the cycle right after a request fault opens a fresh window.
- R10: A synchronous active-high `rst` clears both pulses, `err_sticky` and `fail_cause`, and returns the monitor to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_err | input | 1 | Clears the sticky error flag and the cause code |
| burst_req | input | 1 | Burst request line; its falling edge opens a window |
| rd_strobe | input | 1 | Read-enable response strobe |
| ack_strobe | input | 1 | Acknowledge response strobe |
| win_pass | output | 1 | One-cycle pulse: window completed correctly |
| win_fail | output | 1 | One-cycle pulse: window violated |
| err_sticky | output | 1 | Set by any fail, held until clear or reset |
| fail_cause | output | 2 | 00 none, 01 strobe fault, 10 request fault |

## Verification
The bench probes the latency edge by dropping the strobes in the first expected cycle and in the middle of the run. A monitor that counts latency off by one would either pass these windows or report the fault one cycle early. The bench raises the request during a latency cycle, where no strobe is expected. A monitor that guards the request only while the strobes are high would miss this fault entirely. The bench also:
- injects a request fault and a strobe fault in the same cycle, to catch wrong priority;
- holds the request low out of reset, to catch a false trigger;
- re-triggers in the cycle right after a fault, to catch a monitor that needs an idle gap;
- sends a clear in the same cycle as a fail, which exposes a flag that drops the new fault.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_STROBE = 2'b01,
        CAUSE_REQ    = 2'b10
    } cause_e;

    typedef struct packed {
        logic   pass;
        logic   fail;
        cause_e cause;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{pass: 1'b0, fail: 1'b0, cause: CAUSE_NONE};

    // Decide the outcome of one active window cycle.
    function automatic verdict_t judge(
        input logic req_high,
        input logic strobes_up,
        input logic in_run,
        input logic last_cycle
    );
        verdict_t v;
        v = VERDICT_IDLE;
        if (req_high) begin
            v.fail  = 1'b1;
            v.cause = CAUSE_REQ;
        end else if (in_run && !strobes_up) begin
            v.fail  = 1'b1;
            v.cause = CAUSE_STROBE;
        end else if (last_cycle) begin
            v.pass  = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/bhm_edge.sv
module bhm_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic fall
);
    logic seen_high;

    always_ff @(posedge clk) begin
        if (rst) seen_high <= 1'b0;
        else     seen_high <= req;
    end

    assign fall = seen_high & ~req;
endmodule

// File: rtl/bhm_window.sv
module bhm_window
    import bhm_pkg::*;
#(
    parameter int LATENCY = 2,
    parameter int MIN_RUN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fall,
    input  logic     req,
    input  logic     strobe_a,
    input  logic     strobe_b,
    output logic     active,
    output verdict_t verdict
);
    localparam int LAST  = LATENCY + MIN_RUN - 1;
    localparam int CNT_W = (LAST < 2) ? 1 : $clog2(LAST + 1);
    localparam logic [CNT_W-1:0] LAT_C  = CNT_W'(LATENCY);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    verdict_t         judged;

    always_comb begin
        judged  = judge(req, strobe_a & strobe_b, cnt >= LAT_C, cnt == LAST_C);
        verdict = active ? judged : VERDICT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (judged.pass || judged.fail) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt    <= cnt + ONE_C;
            end
        end else if (fall) begin
            active <= 1'b1;
            cnt    <= ONE_C;
        end
    end
endmodule

// File: rtl/bhm_report.sv
module bhm_report
    import bhm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  verdict_t   verdict,
    output logic       pass_q,
    output logic       fail_q,
    output logic       err_q,
    output cause_e     cause_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            pass_q <= verdict.pass;
            fail_q <= verdict.fail;
            err_q  <= verdict.fail | (err_q & ~clr);
            if (verdict.fail)  cause_q <= verdict.cause;
            else if (clr)      cause_q <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/burst_hs_monitor.sv
module burst_hs_monitor
    import bhm_pkg::*;
#(
    parameter int LATENCY = 2,
    parameter int MIN_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_err,
    input  logic       burst_req,
    input  logic       rd_strobe,
    input  logic       ack_strobe,
    output logic       win_pass,
    output logic       win_fail,
    output logic       err_sticky,
    output logic [1:0] fail_cause
);
    logic     req_fall;
    logic     win_active;
    verdict_t verdict;
    cause_e   cause_q;

    bhm_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .req  (burst_req),
        .fall (req_fall)
    );

    bhm_window #(.LATENCY(LATENCY), .MIN_RUN(MIN_RUN)) u_window (
        .clk      (clk),
        .rst      (rst),
        .fall     (req_fall),
        .req      (burst_req),
        .strobe_a (rd_strobe),
        .strobe_b (ack_strobe),
        .active   (win_active),
        .verdict  (verdict)
    );

    bhm_report u_report (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_err),
        .verdict (verdict),
        .pass_q  (win_pass),
        .fail_q  (win_fail),
        .err_q   (err_sticky),
        .cause_q (cause_q)
    );

    assign fail_cause = cause_q;
endmodule

// File: rtl/bhm_checker.sv
module bhm_checker (
    input logic       clk,
    input logic       rst,
    input logic       clr_err,
    input logic       burst_req,
    input logic       win_active,
    input logic       win_pass,
    input logic       win_fail,
    input logic       err_sticky,
    input logic [1:0] fail_cause
);
    logic req_was_high;

    always_ff @(posedge clk) begin
        if (rst) req_was_high <= 1'b0;
        else     req_was_high <= burst_req;
    end

    assert_trigger_opens_R1: assert property (@(posedge clk) disable iff (rst)
        (req_was_high && !burst_req && !win_active) |=> win_active);

    assert_cold_low_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_was_high && !win_active) |=> !win_active);

    assert_req_fault_code_R4: assert property (@(posedge clk) disable iff (rst)
        (win_active && burst_req) |=> (win_fail && fail_cause == 2'b10));

    assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(win_pass && win_fail));

    assert_window_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (win_pass || win_fail) |-> !win_active);

    assert_cause_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        win_fail |-> (fail_cause != 2'b00));

    assert_sticky_on_fail_R8: assert property (@(posedge clk) disable iff (rst)
        win_fail |-> err_sticky);

    assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !clr_err) |=> err_sticky);
endmodule

bind burst_hs_monitor bhm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_err    (clr_err),
    .burst_req  (burst_req),
    .win_active (win_active),
    .win_pass   (win_pass),
    .win_fail   (win_fail),
    .err_sticky (err_sticky),
    .fail_cause (fail_cause)
);

// File: tb/burst_hs_monitor_tb.sv
module burst_hs_monitor_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr_err = 1'b0;
    logic       burst_req = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       ack_strobe = 1'b0;
    logic       win_pass, win_fail, err_sticky;
    logic [1:0] fail_cause;

    typedef struct {
        int         cyc;
        bit         is_fail;
        logic [1:0] cause;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   n_pulses = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    burst_hs_monitor u_dut (
        .clk        (clk),
        .rst        (rst),
        .clr_err    (clr_err),
        .burst_req  (burst_req),
        .rd_strobe  (rd_strobe),
        .ack_strobe (ack_strobe),
        .win_pass   (win_pass),
        .win_fail   (win_fail),
        .err_sticky (err_sticky),
        .fail_cause (fail_cause)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // scoreboard monitor: pops expected pulses and compares at mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (win_pass || win_fail) n_pulses++;
            if (q.size() > 0 && q[0].cyc < cyc) begin
                chk(1'b0, {q[0].tag, " missing pulse"}, 0, 1);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                if (q[0].is_fail) begin
                    chk(win_fail && !win_pass, {q[0].tag, " fail pulse"}, int'(win_fail), 1);
                    chk(fail_cause == q[0].cause, {q[0].tag, " cause"}, int'(fail_cause), int'(q[0].cause));
                end else begin
                    chk(win_pass && !win_fail, {q[0].tag, " pass pulse"}, int'(win_pass), 1);
                end
                void'(q.pop_front());
            end else if (win_pass || win_fail) begin
                chk(1'b0, "R6 unexpected pulse", int'({win_pass, win_fail}), 0);
            end
        end
    end

    task automatic drive(input bit r, input bit a, input bit b,
                         input bit ev, input bit isf, input logic [1:0] c, input string tag);
        burst_req  = r;
        rd_strobe  = a;
        ack_strobe = b;
        if (ev) q.push_back('{cyc: cyc + 1, is_fail: isf, cause: c, tag: tag});
        @(posedge clk);
        #1;
    endtask

    // kind: 0 clean, 1 both strobes low, 2 ack only low, 3 request high, 4 request high and strobes low
    task automatic burst(input int kind, input int at, input bit pre, input int tail,
                         input bit clr_v, input string tag);
        if (pre) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, tag);
        for (int k = 0; k < 6; k++) begin
            bit hit, r, a, b;
            hit = (kind != 0) && (k == at);
            r = hit && (kind >= 3);
            a = (k >= 2) && !(hit && (kind == 1 || kind == 4));
            b = (k >= 2) && !(hit && (kind == 1 || kind == 2 || kind == 4));
            if (hit) begin
                clr_err = clr_v;
                drive(r, a, b, 1'b1, 1'b1, (kind >= 3) ? 2'b10 : 2'b01, tag);
                clr_err = 1'b0;
                return;
            end
            drive(r, a, b, (k == 5), 1'b0, 2'b00, tag);
        end
        for (int t = 0; t < tail; t++) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(!win_pass && !win_fail && !err_sticky && fail_cause == 2'b00, "R10 reset state",
            int'({win_pass, win_fail, err_sticky, fail_cause}), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R2: low out of reset with strobes high must open nothing
        for (int i = 0; i < 8; i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R2");
        @(negedge clk);
        chk(n_pulses == 0 && !err_sticky, "R2 no window from cold low", n_pulses, 0);
        @(posedge clk);
        #1;
        // R1/R5 clean burst, strobes held past the run
        burst(0, 0, 1'b1, 3, 1'b0, "R1 R5 clean burst");
        @(negedge clk);
        chk(!err_sticky, "R8 pass leaves sticky low", int'(err_sticky), 0);
        @(posedge clk);
        #1;
        // R3 strobes late at first run cycle
        burst(1, 2, 1'b1, 0, 1'b0, "R3 late strobes");
        @(negedge clk);
        chk(err_sticky, "R8 sticky after fail", int'(err_sticky), 1);
        @(posedge clk);
        #1;
        burst(2, 4, 1'b1, 0, 1'b0, "R3 ack drop mid run");
        burst(2, 5, 1'b1, 0, 1'b0, "R3 ack drop last cycle");
        // R4 request high in a latency cycle
        burst(3, 1, 1'b1, 0, 1'b0, "R4 request in latency");
        burst(0, 0, 1'b1, 1, 1'b0, "R7 clean after fault");
        @(negedge clk);
        chk(fail_cause == 2'b10 && err_sticky, "R7 cause held through pass", int'(fail_cause), 2);
        @(posedge clk);
        #1;
        clr_err = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, "R8 clear");
        clr_err = 1'b0;
        @(negedge clk);
        chk(!err_sticky, "R8 cleared", int'(err_sticky), 0);
        chk(fail_cause == 2'b00, "R7 cause cleared", int'(fail_cause), 0);
        @(posedge clk);
        #1;
        // R4 priority over strobe in same cycle
        burst(4, 3, 1'b1, 0, 1'b0, "R4 priority");
        // R9 re-trigger right after a request fault
        burst(3, 3, 1'b1, 0, 1'b0, "R9 fault before retrigger");
        burst(0, 0, 1'b0, 0, 1'b0, "R9 immediate retrigger");
        clr_err = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, "R8 clear");
        clr_err = 1'b0;
        // R8 fail and clear in the same cycle: fail wins
        burst(1, 3, 1'b1, 0, 1'b1, "R8 clear with fail");
        @(negedge clk);
        chk(err_sticky && fail_cause == 2'b01, "R8 fail beats clear", int'(err_sticky), 1);
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, "drain");
        chk(q.size() == 0, "R6 all expected pulses seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule